// File: doc/BRIEF.md
# Standby Wake and Turbo Boost Sequencer

This block governs the transition of a six-channel DAC controller between its active and low-power standby modes. In standby it watches a raw wake pin. The pin is passed through a two-flop synchronizer. The active level is taken from a programmable polarity field, and in two of that field's settings the level also depends on the controller's trigger-select and trigger-edge configuration. When the level is valid, the block emits a one-cycle hardware wake pulse and returns the device to active mode. A software wake strobe also ends standby.

When the device leaves standby, the block can run a timed "turbo up" window on the DAC channels. Whether the window runs depends on the turbo mode and on the wake source. It begins on a selectable start event: either the first falling edge of the low-supply flag, or the oscillator-running flag. It lasts for either a short or a long cycle count. Channels whose DAC code is zero are excluded.

Software sets the behaviour through one control byte. The layout is:

- bits 7:6: wake polarity
- bit 5: hardware wake disable
- bits 4:3: turbo mode
- bit 2: long latency
- bit 1: start on oscillator
- bit 0: ignored

The byte resets to 0x40. A power-mode write port enters standby with code 10 and forces startup with code 01.

Top module: `wake_turbo_seq`

## Requirements
- R1: After `rst`, `mode_o` is 0 (active), `hw_wake` is 0 and every `turbo` bit is 0. The control byte is 0x40: wake polarity 01 (pin active high), hardware wake enabled, turbo mode 00.
- R2: The wake polarity field (bits 7:6) selects the pin's active level. 00 means low and 01 means high. 10 means low when `trig_sel`=1, and otherwise equals `trig_edge`. 11 means high when `trig_sel`=1, and otherwise equals the inverse of `trig_edge`.
- R3: A pin held at its active level in standby produces exactly one `hw_wake` pulse. The pulse appears at the third rising edge after the pin change, and `mode_o` returns to 0 on the same edge. A pin at its active level while in active mode produces no pulse.
- R4: With bit 5 set, hardware wake never occurs and the block stays in standby.
- R5: Bits 7:5 are captured when standby is entered (`pm_we` with `pm_wdata`=10 while active). Writes to those bits during standby take effect only after the next return to active.
- R6: A `sw_wake` pulse in standby returns `mode_o` to 0 on the next edge.
- R7: Turbo mode (bits 4:3) controls the window on wake. 01 applies it on any wake. 10 applies it only on a hardware wake. 00 and 11 never apply it.
- R8: A channel whose DAC code is 0x00 when the window starts never raises its `turbo` bit.
- R9: The window lasts SHORT cycles when bit 2 is 0 and LONG cycles when bit 2 is 1. The bench's parameters give SHORT=20 and LONG=40.
- R10: When bit 1 is 1, the window opens one edge after wake if `osc_run` is high. When bit 1 is 0, the window waits for a 1-to-0 transition of `vlow` and opens on the edge that samples it; `osc_run` has no effect in this case.
- R11: Entering standby ends any window in progress on the same edge. `turbo` is 0 whenever `mode_o` is 1.
- R12: A `soft_rst` pulse restores the control byte to 0x40. A power-mode write of 01 does the same, and also forces `mode_o` to 0.
- R13: All eligible channels raise and drop their `turbo` bits on the same edges, and the set does not change while the window runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high digital reset |
| soft_rst | input | 1 | Software reset pulse for the control byte |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| pm_we | input | 1 | Power-mode write strobe |
| pm_wdata | input | 2 | Power-mode code: 10 standby, 01 startup |
| wake_pin | input | 1 | Raw asynchronous wake pin |
| trig_sel | input | 1 | Trigger-select configuration bit |
| trig_edge | input | 1 | Trigger-edge configuration bit |
| sw_wake | input | 1 | Software wake strobe |
| vlow | input | 1 | Low-supply flag |
| osc_run | input | 1 | Oscillator-running flag |
| dac_flat | input | NCH*DW (48) | DAC codes, channel i at bits i*DW +: DW |
| hw_wake | output | 1 | One-cycle hardware wake pulse |
| mode_o | output | 1 | 0 active, 1 standby |
| turbo | output | NCH (6) | Per-channel turbo-active flags |

## Verification
The hardest state to reach is one where the captured wake configuration and the live register disagree. To get there, the bench enters standby with one polarity and enable setting, then rewrites the byte to a setting that would react differently to the current pin level. It then shows that only the captured copy governs the wake. After wake, it re-enters standby and shows that the new byte now applies. The vlow-started window is another hard case. It is reached by holding `vlow` high through the wake, with `osc_run` already high, so that a premature start would be visible before `vlow` is released.

// File: rtl/wts_pkg.sv
package wts_pkg;

    typedef enum logic [0:0] {
        MODE_ACTIVE  = 1'b0,
        MODE_STANDBY = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        POL_LOW       = 2'b00,
        POL_HIGH      = 2'b01,
        POL_INV_TRIG  = 2'b10,
        POL_SAME_TRIG = 2'b11
    } wpol_e;

    typedef enum logic [1:0] {
        TB_NEVER   = 2'b00,
        TB_ALWAYS  = 2'b01,
        TB_HW_ONLY = 2'b10,
        TB_RSVD    = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        TS_IDLE = 2'b00,
        TS_WAIT = 2'b01,
        TS_RUN  = 2'b10
    } tstate_e;

    // Control byte bits 7:1; bit 0 carries nothing
    typedef struct packed {
        wpol_e  pol;
        logic   hw_dis;
        tmode_e tmode;
        logic   lat_long;
        logic   start_osc;
    } ctl_t;

    // Portion that is frozen across standby
    typedef struct packed {
        wpol_e pol;
        logic  hw_dis;
    } wake_cfg_t;

    localparam ctl_t CTL_DEFAULT = '{
        pol:       POL_HIGH,
        hw_dis:    1'b0,
        tmode:     TB_NEVER,
        lat_long:  1'b0,
        start_osc: 1'b0
    };

    localparam logic [1:0] PM_STARTUP = 2'b01;
    localparam logic [1:0] PM_STANDBY = 2'b10;

    function automatic logic wake_level_high(wpol_e pol, logic tsel, logic tedge);
        logic hi;
        case (pol)
            POL_LOW:       hi = 1'b0;
            POL_HIGH:      hi = 1'b1;
            POL_INV_TRIG:  hi = tsel ? 1'b0 : tedge;
            default:       hi = tsel ? 1'b1 : ~tedge;
        endcase
        return hi;
    endfunction

    function automatic logic turbo_wanted(tmode_e m, logic from_hw);
        logic w;
        case (m)
            TB_ALWAYS:  w = 1'b1;
            TB_HW_ONLY: w = from_hw;
            default:    w = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wts_ctl_bank.sv
module wts_ctl_bank
    import wts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       pm_we,
    input  logic [1:0] pm_wdata,
    input  logic       wake_hw,
    input  logic       sw_wake,
    output ctl_t       ctl_q,
    output wake_cfg_t  wcfg_eff,
    output mode_e      mode_q,
    output logic       enter_sb,
    output logic       startup,
    output logic       wake_go
);

    wake_cfg_t shadow_q;
    logic      ctl_unused_bit;

    assign ctl_unused_bit = ctl_wdata[0];

    assign startup  = pm_we && (pm_wdata == PM_STARTUP);
    assign enter_sb = pm_we && (pm_wdata == PM_STANDBY) && (mode_q == MODE_ACTIVE);
    assign wake_go  = (mode_q == MODE_STANDBY) && (wake_hw || sw_wake) && !startup;

    // In standby the frozen copy governs the wake logic
    always_comb begin
        if (mode_q == MODE_STANDBY) begin
            wcfg_eff = shadow_q;
        end else begin
            wcfg_eff.pol    = ctl_q.pol;
            wcfg_eff.hw_dis = ctl_q.hw_dis;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || startup || soft_rst) begin
            ctl_q <= CTL_DEFAULT;
        end else if (ctl_we) begin
            ctl_q <= ctl_t'(ctl_wdata[7:1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || startup) begin
            shadow_q.pol    <= CTL_DEFAULT.pol;
            shadow_q.hw_dis <= CTL_DEFAULT.hw_dis;
        end else if (enter_sb) begin
            shadow_q.pol    <= ctl_q.pol;
            shadow_q.hw_dis <= ctl_q.hw_dis;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || startup) begin
            mode_q <= MODE_ACTIVE;
        end else if (enter_sb) begin
            mode_q <= MODE_STANDBY;
        end else if (wake_go) begin
            mode_q <= MODE_ACTIVE;
        end
    end

endmodule

// File: rtl/wts_wake_detect.sv
module wts_wake_detect
    import wts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw,
    input  logic      trig_sel,
    input  logic      trig_edge,
    input  wake_cfg_t cfg,
    input  logic      in_standby,
    output logic      wake_cond,
    output logic      wake_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   lvl_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
        end
    end

    assign pin_s     = sync_q[SYNC_STAGES-1];
    assign lvl_hi    = wake_level_high(cfg.pol, trig_sel, trig_edge);
    assign wake_cond = in_standby && !cfg.hw_dis && (pin_s == lvl_hi);

    // Leaving standby on the same edge keeps this a single-cycle pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= wake_cond;
        end
    end

endmodule

// File: rtl/wts_turbo.sv
module wts_turbo
    import wts_pkg::*;
#(
    parameter int NCH       = 6,
    parameter int DW        = 8,
    parameter int SHORT_CYC = 5000,
    parameter int LONG_CYC  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              wake_go,
    input  logic              wake_hw,
    input  ctl_t              ctl,
    input  logic              vlow,
    input  logic              osc_run,
    input  logic [NCH*DW-1:0] dac_flat,
    output logic [NCH-1:0]    turbo
);

    localparam int CW = $clog2(LONG_CYC + 1);

    tstate_e          state_q;
    logic [CW-1:0]    cnt_q;
    logic             lat_long_q;
    logic             start_osc_q;
    logic             vlow_q;
    logic [NCH-1:0]   mask_q;
    logic [NCH-1:0]   nz;
    logic             start_evt;
    logic [CW-1:0]    load_val;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign nz[i]    = |dac_flat[i*DW +: DW];
            assign turbo[i] = (state_q == TS_RUN) && mask_q[i];
        end
    endgenerate

    assign start_evt = start_osc_q ? osc_run : (vlow_q && !vlow);
    assign load_val  = lat_long_q ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            vlow_q <= 1'b0;
        end else begin
            vlow_q <= vlow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state_q     <= TS_IDLE;
            cnt_q       <= '0;
            mask_q      <= '0;
            lat_long_q  <= 1'b0;
            start_osc_q <= 1'b0;
        end else begin
            case (state_q)
                TS_IDLE: begin
                    if (wake_go && turbo_wanted(ctl.tmode, wake_hw)) begin
                        state_q     <= TS_WAIT;
                        lat_long_q  <= ctl.lat_long;
                        start_osc_q <= ctl.start_osc;
                    end
                end
                TS_WAIT: begin
                    if (start_evt) begin
                        state_q <= TS_RUN;
                        cnt_q   <= load_val;
                        mask_q  <= nz;
                    end
                end
                TS_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= TS_IDLE;
                        mask_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= TS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wake_turbo_seq.sv
module wake_turbo_seq
    import wts_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int DW       = 8,
    parameter int CLK_KHZ  = 100000,
    parameter int SHORT_US = 50,
    parameter int LONG_US  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              pm_we,
    input  logic [1:0]        pm_wdata,
    input  logic              wake_pin,
    input  logic              trig_sel,
    input  logic              trig_edge,
    input  logic              sw_wake,
    input  logic              vlow,
    input  logic              osc_run,
    input  logic [NCH*DW-1:0] dac_flat,
    output logic              hw_wake,
    output logic              mode_o,
    output logic [NCH-1:0]    turbo
);

    localparam int SHORT_CYC = (CLK_KHZ * SHORT_US) / 1000;
    localparam int LONG_CYC  = (CLK_KHZ * LONG_US) / 1000;

    ctl_t      ctl_q;
    wake_cfg_t wcfg_eff;
    mode_e     mode_q;
    logic      enter_sb;
    logic      startup;
    logic      wake_go;
    logic      wake_cond;
    logic      eff_hw_dis;

    wts_ctl_bank u_ctl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .pm_we     (pm_we),
        .pm_wdata  (pm_wdata),
        .wake_hw   (wake_cond),
        .sw_wake   (sw_wake),
        .ctl_q     (ctl_q),
        .wcfg_eff  (wcfg_eff),
        .mode_q    (mode_q),
        .enter_sb  (enter_sb),
        .startup   (startup),
        .wake_go   (wake_go)
    );

    wts_wake_detect #(.SYNC_STAGES(2)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (wake_pin),
        .trig_sel   (trig_sel),
        .trig_edge  (trig_edge),
        .cfg        (wcfg_eff),
        .in_standby (mode_q == MODE_STANDBY),
        .wake_cond  (wake_cond),
        .wake_pulse (hw_wake)
    );

    wts_turbo #(
        .NCH       (NCH),
        .DW        (DW),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_turbo (
        .clk      (clk),
        .rst      (rst),
        .abort    (enter_sb || startup),
        .wake_go  (wake_go),
        .wake_hw  (wake_cond),
        .ctl      (ctl_q),
        .vlow     (vlow),
        .osc_run  (osc_run),
        .dac_flat (dac_flat),
        .turbo    (turbo)
    );

    assign mode_o     = mode_q;
    assign eff_hw_dis = wcfg_eff.hw_dis;

endmodule

// File: rtl/wts_checker.sv
module wts_checker #(
    parameter int NCH      = 6,
    parameter int DW       = 8,
    parameter int LONG_CYC = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_i,
    input logic              hw_wake_i,
    input logic              hw_dis_i,
    input logic [NCH-1:0]    turbo_i,
    input logic [NCH*DW-1:0] dac_i
);

    logic [NCH-1:0] nz;
    int unsigned    run_len;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_nz
            assign nz[i] = |dac_i[i*DW +: DW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !(|turbo_i)) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    assert_wake_single_R3: assert property (@(posedge clk) disable iff (rst)
        hw_wake_i |=> !hw_wake_i);

    assert_wake_exit_R3: assert property (@(posedge clk) disable iff (rst)
        hw_wake_i |-> (!mode_i && $past(mode_i)));

    assert_wake_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        hw_wake_i |-> !$past(hw_dis_i));

    assert_quiet_standby_R11: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> (turbo_i == '0));

    assert_zero_excluded_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(|turbo_i) |-> ((turbo_i & ~$past(nz)) == '0));

    assert_group_steady_R13: assert property (@(posedge clk) disable iff (rst)
        ((|turbo_i) && $past(|turbo_i)) |-> (turbo_i == $past(turbo_i)));

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (rst)
        run_len <= LONG_CYC);

endmodule

bind wake_turbo_seq wts_checker #(
    .NCH      (NCH),
    .DW       (DW),
    .LONG_CYC (LONG_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_o),
    .hw_wake_i (hw_wake),
    .hw_dis_i  (eff_hw_dis),
    .turbo_i   (turbo),
    .dac_i     (dac_flat)
);

// File: tb/wake_turbo_seq_bench.sv
`timescale 1ns/1ps
module wake_turbo_seq_bench;

    localparam int NCH   = 6;
    localparam int DW    = 8;
    localparam int SHORT = 20;
    localparam int LONG  = 40;
    localparam logic [NCH-1:0] MASK = 6'b101101;

    // {pol[1:0], trig_sel, trig_edge, pin, expect_wake}
    localparam int NVEC = 13;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_0_0_0_1, 6'b00_0_0_1_0, 6'b01_0_0_1_1, 6'b01_0_0_0_0,
        6'b10_1_0_0_1, 6'b10_1_0_1_0, 6'b10_0_0_0_1, 6'b10_0_1_1_1,
        6'b10_0_1_0_0, 6'b11_1_0_1_1, 6'b11_0_0_1_1, 6'b11_0_1_0_1,
        6'b11_0_1_1_0
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_rst = 1'b0;
    logic              ctl_we = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic              pm_we = 1'b0;
    logic [1:0]        pm_wdata = '0;
    logic              wake_pin = 1'b0;
    logic              trig_sel = 1'b0;
    logic              trig_edge = 1'b0;
    logic              sw_wake = 1'b0;
    logic              vlow = 1'b0;
    logic              osc_run = 1'b1;
    logic [NCH*DW-1:0] dac_flat;
    logic              hw_wake;
    logic              mode_o;
    logic [NCH-1:0]    turbo;

    int nchk = 0;
    int nfail = 0;
    int hw_total = 0;
    int tb_total [NCH];
    int hw_snap;
    int tb_snap [NCH];

    assign dac_flat = {8'h80, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h10};

    always #5 clk = ~clk;

    wake_turbo_seq #(
        .NCH(NCH), .DW(DW), .CLK_KHZ(400), .SHORT_US(50), .LONG_US(100)
    ) u_wake_turbo_seq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .pm_we(pm_we), .pm_wdata(pm_wdata),
        .wake_pin(wake_pin), .trig_sel(trig_sel), .trig_edge(trig_edge),
        .sw_wake(sw_wake), .vlow(vlow), .osc_run(osc_run),
        .dac_flat(dac_flat), .hw_wake(hw_wake), .mode_o(mode_o), .turbo(turbo)
    );

    initial for (int i = 0; i < NCH; i++) tb_total[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (hw_wake) hw_total++;
            for (int i = 0; i < NCH; i++) if (turbo[i]) tb_total[i]++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snap();
        hw_snap = hw_total;
        for (int i = 0; i < NCH; i++) tb_snap[i] = tb_total[i];
    endtask

    task automatic check_turbo_len(string req, int len);
        for (int i = 0; i < NCH; i++)
            check_eq(req, tb_total[i] - tb_snap[i], MASK[i] ? len : 0);
    endtask

    task automatic write_ctl(logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
    endtask

    task automatic pm_write(logic [1:0] c);
        pm_we = 1'b1; pm_wdata = c; tick(); pm_we = 1'b0;
    endtask

    task automatic pulse_sw_wake();
        sw_wake = 1'b1; tick(); sw_wake = 1'b0;
    endtask

    task automatic settle();
        repeat (3) tick();
    endtask

    // Enter standby with the pin low (inactive for polarity 01), then wake
    task automatic turbo_case(string req, logic [7:0] c, bit by_hw, int len);
        write_ctl(c);
        wake_pin = 1'b0; osc_run = 1'b1; settle();
        pm_write(2'b10);
        tick();
        snap();
        if (by_hw) wake_pin = 1'b1;
        else pulse_sw_wake();
        repeat (60) tick();
        check_eq(req, int'(mode_o), 0);
        check_turbo_len(req, len);
        wake_pin = 1'b0; settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check_eq("R1 mode", int'(mode_o), 0);
        check_eq("R1 hw_wake", int'(hw_wake), 0);
        check_eq("R1 turbo", int'(turbo), 0);
        // R1 default byte: active-high, enabled, no turbo
        wake_pin = 1'b1; settle(); snap();
        pm_write(2'b10); repeat (40) tick();
        check_eq("R1 default wakes", hw_total - hw_snap, 1);
        check_eq("R1 default mode", int'(mode_o), 0);
        check_turbo_len("R1 default no turbo", 0);
        // R3 no pulse in active mode with pin active
        snap(); repeat (8) tick();
        check_eq("R3 no pulse active", hw_total - hw_snap, 0);
        wake_pin = 1'b0; settle();

        // R2 polarity table
        for (int v = 0; v < NVEC; v++) begin
            write_ctl({VEC[v][5:4], 6'b000000});
            trig_sel = VEC[v][3]; trig_edge = VEC[v][2]; wake_pin = VEC[v][1];
            settle(); snap();
            pm_write(2'b10);
            repeat (5) tick();
            check_eq("R2 wake count", hw_total - hw_snap, int'(VEC[v][0]));
            check_eq("R2 mode", int'(mode_o), VEC[v][0] ? 0 : 1);
            if (mode_o) begin
                pulse_sw_wake();
                check_eq("R6 sw wake", int'(mode_o), 0);
            end
        end
        trig_sel = 1'b0; trig_edge = 1'b0; wake_pin = 1'b0;

        // R3 exact latency
        write_ctl(8'h40); settle();
        pm_write(2'b10); tick(); tick();
        wake_pin = 1'b1;
        tick();
        check_eq("R3 edge1 hw", int'(hw_wake), 0);
        tick();
        check_eq("R3 edge2 hw", int'(hw_wake), 0);
        check_eq("R3 edge2 mode", int'(mode_o), 1);
        tick();
        check_eq("R3 edge3 hw", int'(hw_wake), 1);
        check_eq("R3 edge3 mode", int'(mode_o), 0);
        tick();
        check_eq("R3 single", int'(hw_wake), 0);
        wake_pin = 1'b0; settle();

        // R4 disable
        write_ctl(8'h60); wake_pin = 1'b1; settle(); snap();
        pm_write(2'b10); repeat (6) tick();
        check_eq("R4 no wake", hw_total - hw_snap, 0);
        check_eq("R4 stays standby", int'(mode_o), 1);
        pulse_sw_wake();
        check_eq("R6 sw wake after disable", int'(mode_o), 0);
        wake_pin = 1'b0; settle();

        // R5 shadow
        write_ctl(8'h40); settle(); snap();
        pm_write(2'b10);
        write_ctl(8'h00);
        repeat (6) tick();
        check_eq("R5 live write ignored", int'(mode_o), 1);
        write_ctl(8'h20);
        wake_pin = 1'b1; repeat (6) tick();
        check_eq("R5 shadow wakes", hw_total - hw_snap, 1);
        check_eq("R5 shadow mode", int'(mode_o), 0);
        snap();
        pm_write(2'b10); repeat (6) tick();
        check_eq("R5 new byte applies", hw_total - hw_snap, 0);
        check_eq("R5 new byte mode", int'(mode_o), 1);
        pulse_sw_wake();
        wake_pin = 1'b0; settle();

        // R7/R8/R9 turbo cases
        turbo_case("R7 mode01 sw R8 R9 short", 8'h4A, 1'b0, SHORT);
        turbo_case("R9 long", 8'h4E, 1'b0, LONG);
        turbo_case("R7 mode10 sw none", 8'h52, 1'b0, 0);
        turbo_case("R7 mode10 hw", 8'h52, 1'b1, SHORT);
        turbo_case("R7 mode11 none", 8'h5E, 1'b1, 0);
        turbo_case("R7 mode00 latency ignored", 8'h46, 1'b1, 0);

        // R10/R13 oscillator start timing
        write_ctl(8'h4A); settle();
        pm_write(2'b10); tick();
        pulse_sw_wake();
        check_eq("R10 osc edge1", int'(turbo), 0);
        tick();
        check_eq("R13 together osc edge2", int'(turbo), int'(MASK));
        repeat (60) tick();

        // R10 vlow falling edge start
        write_ctl(8'h48); vlow = 1'b1; osc_run = 1'b1; settle();
        pm_write(2'b10); tick(); snap();
        pulse_sw_wake();
        repeat (10) tick();
        check_eq("R10 waits for vlow", int'(turbo), 0);
        check_turbo_len("R10 nothing before edge", 0);
        vlow = 1'b0;
        tick();
        check_eq("R10 vlow edge start", int'(turbo), int'(MASK));
        repeat (60) tick();
        check_turbo_len("R10 vlow window", SHORT);

        // R11 abort
        write_ctl(8'h4A); settle();
        pm_write(2'b10); tick(); snap();
        pulse_sw_wake();
        repeat (5) tick();
        pm_write(2'b10);
        check_eq("R11 abort turbo", int'(turbo), 0);
        check_eq("R11 mode", int'(mode_o), 1);
        repeat (30) tick();
        for (int i = 0; i < NCH; i++) begin
            int d = tb_total[i] - tb_snap[i];
            check_eq("R11 cut short", int'(d < SHORT), 1);
        end
        pulse_sw_wake();
        settle();

        // R12 soft reset
        write_ctl(8'h60); soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        wake_pin = 1'b1; settle(); snap();
        pm_write(2'b10); repeat (5) tick();
        check_eq("R12 soft reset default", hw_total - hw_snap, 1);
        check_eq("R12 soft reset mode", int'(mode_o), 0);
        // R12 startup
        write_ctl(8'h60); settle();
        pm_write(2'b10); repeat (4) tick();
        check_eq("R12 disabled standby", int'(mode_o), 1);
        pm_write(2'b01);
        check_eq("R12 startup active", int'(mode_o), 0);
        snap();
        pm_write(2'b10); repeat (5) tick();
        check_eq("R12 startup default", hw_total - hw_snap, 1);
        wake_pin = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule